// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

A non-blocking time-slot interchange for a small set of serial TDM streams. Every input stream and every output stream runs at its own bit rate: 2.048, 4.096, 8.192 or 16.384 Mbps. Each frame lasts 125 us and carries 32, 64, 128 or 256 eight-bit channels, depending on the stream's rate. Input bits are collected into bytes and stored in a rotating data memory. A connection memory holds one entry per output channel. Each entry names the source stream, the source channel and an enable bit. Because the source may run at a different rate from the output, the block converts rates as it switches.

One `clk_i` cycle is one bit time at 16.384 Mbps, so a frame is 2048 cycles. Bit and channel timing for every stream comes from a shared frame counter. The data memory rotates over three banks in step with that counter. This keeps the delay from an input channel to an output channel at exactly two frames, whatever the positions of the two channels. A single write port loads the connection entries and the rate registers. The write port has no read side.

Top module: `tsi_switch`

## Requirements
- R1: After reset every output-enable is low, every connection entry is disabled, and every stream runs at rate code 0 (2.048 Mbps).
- R2: A frame is 2048 clock cycles and starts when the counter leaves reset. A stream with rate code r (0..3) has a bit time of 8>>r cycles and 32<<r channels. Channel 0 starts at the frame boundary, and each byte moves most significant bit first.
- R3: Rate codes are 0 = 2.048, 1 = 4.096, 2 = 8.192 and 3 = 16.384 Mbps. Each input stream and each output stream has its own code, in any combination.
- R4: Any input channel of any stream can feed any output channel of any stream, including several outputs from the same source.
- R5: The byte sent in an enabled output channel during frame F is the source byte received during frame F-2.
- R6: When an entry's enable bit (data bit 1+SW+7, the top bit) is clear, the output-enable of that channel is low for the whole time slot.
- R7: A rate write takes effect at the next frame boundary. The frame in progress keeps its old timing.
- R8: The write address decodes as follows. If bit AW-1 is 0, the write goes to a connection entry, with the output stream at bits [8+:SW] and the output channel at bits [7:0]. If bit AW-1 is 1, the write goes to a rate register: bit SW selects output (1) or input (0), bits [SW-1:0] select the stream, and data bits [1:0] give the code. Connection data holds the source channel at [7:0], the source stream at [8+:SW] and the enable bit at the top. A connection write takes effect on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, one cycle per 16.384 Mbps bit |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ser_i | input | N_STREAMS | Serial input streams |
| ser_o | output | N_STREAMS | Serial output data |
| ser_oe_o | output | N_STREAMS | Per-stream output-enable for the current channel |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | AW | Write address |
| wr_data_i | input | EW | Write data |

## Verification
The assertions assume that `rst_ni` is released once and that the frame counter then runs freely. The rate-hold and bank-hold checks depend on this, because frame boundaries come only from that counter. They also assume the write port never sets a rate in the last cycle of a frame. The stimulus therefore drives inputs and writes only at falling edges. It issues every rate write well inside a frame, and it asserts reset once, before the first frame.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int CHW   = 8;    // channel index width at the fastest rate
  localparam int NCH   = 1 << CHW;
  localparam int TICKW = CHW + 3;
  localparam int NBANK = 3;

  // bit index within frame for a stream of rate code r
  function automatic logic [TICKW-1:0] bit_idx(input logic [TICKW-1:0] tick, input logic [1:0] rate);
    return tick >> (2'd3 - rate);
  endfunction

  function automatic logic bit_start(input logic [TICKW-1:0] tick, input logic [1:0] rate);
    logic [TICKW-1:0] m;
    m = (TICKW'(1) << (2'd3 - rate)) - TICKW'(1);
    return (tick & m) == '0;
  endfunction
endpackage

// File: rtl/tsi_timebase.sv
module tsi_timebase
  import tsi_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [TICKW-1:0] tick_o,
  output logic             frame_end_o,
  output logic [1:0]       wbank_o,
  output logic [1:0]       rbank_o
);
  logic [TICKW-1:0] tick_q;
  logic [1:0]       bank_q;

  assign frame_end_o = &tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= '0;
      bank_q <= '0;
    end else begin
      tick_q <= tick_q + TICKW'(1);
      if (frame_end_o) bank_q <= (bank_q == 2'(NBANK - 1)) ? 2'd0 : bank_q + 2'd1;
    end
  end

  assign tick_o  = tick_q;
  assign wbank_o = bank_q;
  // bank written two frames ago
  assign rbank_o = (bank_q == 2'(NBANK - 1)) ? 2'd0 : bank_q + 2'd1;
endmodule

// File: rtl/tsi_rx.sv
module tsi_rx
  import tsi_pkg::*;
#(
  parameter int N_RD = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      din_i,
  input  logic [1:0]                rate_i,
  input  logic [TICKW-1:0]          tick_i,
  input  logic [1:0]                wbank_i,
  input  logic [1:0]                rbank_i,
  input  logic [N_RD-1:0][CHW-1:0]  rd_ch_i,
  output logic [N_RD-1:0][7:0]      rd_byte_o
);
  logic [7:0]       mem_q [NBANK*NCH];
  logic [6:0]       sh_q;
  logic [TICKW-1:0] bi;
  logic             strobe;

  assign bi     = bit_idx(tick_i, rate_i);
  assign strobe = bit_start(tick_i, rate_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else if (strobe) sh_q <= {sh_q[5:0], din_i};
  end

  always_ff @(posedge clk_i) begin
    if (strobe && bi[2:0] == 3'd7) mem_q[{wbank_i, bi[TICKW-1:3]}] <= {sh_q, din_i};
  end

  for (genvar k = 0; k < N_RD; k++) begin : g_rd
    assign rd_byte_o[k] = mem_q[{rbank_i, rd_ch_i[k]}];
  end
endmodule

// File: rtl/tsi_tx.sv
module tsi_tx
  import tsi_pkg::*;
#(
  parameter int SW = 1,
  localparam int EW = 1 + SW + CHW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       rate_i,
  input  logic [TICKW-1:0] tick_i,
  input  logic             cw_en_i,
  input  logic [CHW-1:0]   cw_ch_i,
  input  logic [EW-1:0]    cw_data_i,
  output logic [SW-1:0]    src_o,
  output logic [CHW-1:0]   src_ch_o,
  input  logic [7:0]       byte_i,
  output logic             dout_o,
  output logic             oe_o
);
  logic [EW-1:0]    conn_q [NCH];
  logic [EW-1:0]    cur;
  logic [TICKW-1:0] bi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NCH; i++) conn_q[i] <= '0;
    end else if (cw_en_i) begin
      conn_q[cw_ch_i] <= cw_data_i;
    end
  end

  assign bi       = bit_idx(tick_i, rate_i);
  assign cur      = conn_q[bi[TICKW-1:3]];
  assign src_ch_o = cur[CHW-1:0];
  assign src_o    = cur[CHW +: SW];
  assign oe_o     = cur[EW-1];
  assign dout_o   = byte_i[3'd7 - bi[2:0]];  // MSB first
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
#(
  parameter int N_STREAMS = 2,
  localparam int SW = $clog2(N_STREAMS),
  localparam int EW = 1 + SW + CHW,
  localparam int AW = 1 + SW + CHW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_STREAMS-1:0] ser_i,
  output logic [N_STREAMS-1:0] ser_o,
  output logic [N_STREAMS-1:0] ser_oe_o,
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        wr_addr_i,
  input  logic [EW-1:0]        wr_data_i
);
  logic [TICKW-1:0] tick_w;
  logic             frame_end;
  logic [1:0]       wbank_w, rbank_w;

  logic [N_STREAMS-1:0][1:0] pend_in_q, act_in_q, pend_out_q, act_out_q;

  logic conn_we, rate_we;
  logic [SW-1:0] rate_idx;

  logic [N_STREAMS-1:0][SW-1:0]  tx_src;
  logic [N_STREAMS-1:0][CHW-1:0] tx_src_ch;
  logic [N_STREAMS-1:0][7:0]     rd_byte [N_STREAMS];

  tsi_timebase u_tb (
    .clk_i, .rst_ni,
    .tick_o(tick_w), .frame_end_o(frame_end),
    .wbank_o(wbank_w), .rbank_o(rbank_w)
  );

  assign conn_we  = wr_en_i & ~wr_addr_i[AW-1];
  assign rate_we  = wr_en_i &  wr_addr_i[AW-1];
  assign rate_idx = wr_addr_i[SW-1:0];

  // rates are staged and switch over only at the frame boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_in_q  <= '0;
      act_in_q   <= '0;
      pend_out_q <= '0;
      act_out_q  <= '0;
    end else begin
      if (rate_we && !wr_addr_i[SW]) pend_in_q[rate_idx]  <= wr_data_i[1:0];
      if (rate_we &&  wr_addr_i[SW]) pend_out_q[rate_idx] <= wr_data_i[1:0];
      if (frame_end) begin
        act_in_q  <= pend_in_q;
        act_out_q <= pend_out_q;
      end
    end
  end

  for (genvar i = 0; i < N_STREAMS; i++) begin : g_in
    tsi_rx #(.N_RD(N_STREAMS)) u_rx (
      .clk_i, .rst_ni,
      .din_i(ser_i[i]), .rate_i(act_in_q[i]), .tick_i(tick_w),
      .wbank_i(wbank_w), .rbank_i(rbank_w),
      .rd_ch_i(tx_src_ch), .rd_byte_o(rd_byte[i])
    );
  end

  for (genvar o = 0; o < N_STREAMS; o++) begin : g_out
    logic cw_en;
    assign cw_en = conn_we && (wr_addr_i[CHW +: SW] == SW'(o));
    tsi_tx #(.SW(SW)) u_tx (
      .clk_i, .rst_ni,
      .rate_i(act_out_q[o]), .tick_i(tick_w),
      .cw_en_i(cw_en), .cw_ch_i(wr_addr_i[CHW-1:0]), .cw_data_i(wr_data_i),
      .src_o(tx_src[o]), .src_ch_o(tx_src_ch[o]),
      .byte_i(rd_byte[tx_src[o]][o]),
      .dout_o(ser_o[o]), .oe_o(ser_oe_o[o])
    );
  end
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk
  import tsi_pkg::*;
#(
  parameter int N_STREAMS = 2
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [TICKW-1:0]          tick_i,
  input logic [1:0]                wbank_i,
  input logic [N_STREAMS-1:0][1:0] act_in_i,
  input logic [N_STREAMS-1:0][1:0] act_out_i
);
  AST_IN_RATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i != '0) |-> $stable(act_in_i)); // R7
  AST_OUT_RATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i != '0) |-> $stable(act_out_i)); // R7
  AST_FRAME_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&tick_i) |=> (tick_i == '0)); // R2
  AST_BANK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i != '0) |-> $stable(wbank_i)); // R5
  AST_BANK_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wbank_i != 2'd3)); // R5
endmodule

bind tsi_switch tsi_switch_chk #(.N_STREAMS(N_STREAMS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_w), .wbank_i(wbank_w),
  .act_in_i(act_in_q), .act_out_i(act_out_q)
);

// File: tb/tsi_switch_test.sv
module tsi_switch_test;
  localparam int N   = 2;
  localparam int SW  = 1;
  localparam int CHW = 8;
  localparam int EW  = 1 + SW + CHW;
  localparam int AW  = 1 + SW + CHW;
  localparam int FT  = 2048;
  localparam int NF  = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_ni;
  logic [N-1:0]  ser_i, ser_o, ser_oe_o;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [EW-1:0] wr_data;

  tsi_switch #(.N_STREAMS(N)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .ser_i(ser_i), .ser_o(ser_o), .ser_oe_o(ser_oe_o),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] sent [3][N][256];
  int hist_rate [3][N];
  int pend_in [N], act_in [N], pend_out [N], act_out [N];
  int c_en [N][256], c_src [N][256], c_ch [N][256];

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr_rate(input int dir, input int s, input int code);
    wr_en = 1'b1;
    wr_addr = AW'((1 << (AW-1)) | (dir << SW) | s);
    wr_data = EW'(code);
    if (dir == 0) pend_in[s] = code; else pend_out[s] = code;
  endtask

  task automatic wr_conn(input int o, input int ch, input int en, input int src, input int sc);
    wr_en = 1'b1;
    wr_addr = AW'((o << CHW) | ch);
    wr_data = EW'((en << (EW-1)) | (src << CHW) | sc);
    c_en[o][ch] = en; c_src[o][ch] = src; c_ch[o][ch] = sc;
  endtask

  task automatic wr_conn_rand(input int o, input int ch);
    int src;
    src = $urandom % N;
    wr_conn(o, ch, (($urandom % 4) != 0) ? 1 : 0, src, $urandom % (32 << pend_in[src]));
  endtask

  initial begin
    void'($urandom(32'h5a17));
    rst_ni = 1'b0; ser_i = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    for (int s = 0; s < N; s++) begin
      pend_in[s] = 0; act_in[s] = 0; pend_out[s] = 0; act_out[s] = 0;
      for (int c = 0; c < 256; c++) begin c_en[s][c] = 0; c_src[s][c] = 0; c_ch[s][c] = 0; end
    end
    repeat (5) @(negedge clk);
    for (int f = 0; f < NF; f++) begin
      for (int t = 0; t < FT; t++) begin
        if (!(f == 0 && t == 0)) @(negedge clk);
        wr_en = 1'b0;
        if (t == 0) begin
          for (int s = 0; s < N; s++) begin
            act_in[s] = pend_in[s]; act_out[s] = pend_out[s];
            hist_rate[f % 3][s] = act_in[s];
            for (int c = 0; c < 256; c++) sent[f % 3][s][c] = 8'($urandom);
          end
        end
        // output checks for tick t
        for (int o = 0; o < N; o++) begin
          int bi, ch, bp, src, sc;
          string tag;
          bi = t >> (3 - act_out[o]); ch = bi >> 3; bp = bi & 7;
          if (f == 0 && t == 0) begin
            chk("R1", "oe after reset", int'(ser_oe_o[o]), 0);
            continue;
          end
          tag = (c_en[o][ch] == 0) ? "R6" : "R8";
          if (f == 4 && t > 1003) tag = "R7";
          chk(tag, "output enable", int'(ser_oe_o[o]), c_en[o][ch]);
          src = c_src[o][ch]; sc = c_ch[o][ch];
          if (f >= 2 && c_en[o][ch] != 0 && sc < (32 << hist_rate[(f + 1) % 3][src])) begin
            if (f == 4 && t > 1003) tag = "R7";
            else if (o == 0 && ch == 0 && f < 4) tag = "R4";
            else if (ch == 0) tag = "R2";
            else if (hist_rate[(f + 1) % 3][src] != act_out[o]) tag = "R3";
            else tag = "R5";
            chk(tag, "serial data", int'(ser_o[o]), int'(sent[(f + 1) % 3][src][sc][7 - bp]));
          end
        end
        if (f == 0 && t == 0) rst_ni = 1'b1;
        // drive inputs for tick t
        for (int s = 0; s < N; s++) begin
          int bi;
          bi = t >> (3 - act_in[s]);
          ser_i[s] = sent[f % 3][s][bi >> 3][7 - (bi & 7)];
        end
        // configuration writes
        if (f == 0) begin
          if (t == 1) wr_rate(0, 0, 0);
          if (t == 2) wr_rate(0, 1, 3);
          if (t == 3) wr_rate(1, 0, 2);
          if (t == 4) wr_rate(1, 1, 1);
          if (t >= 8 && t < 8 + N * 256) begin
            int o, ch;
            o = (t - 8) >> 8; ch = (t - 8) & 255;
            if (o == 0 && ch == 0) wr_conn(0, 0, 1, 1, 255);   // R4 last 16M channel to channel 0
            else if (o == 1 && ch == 0) wr_conn(1, 0, 0, 0, 0); // R6 disabled slot
            else wr_conn_rand(o, ch);
          end
        end
        if (f == 4) begin
          if (t >= 1000 && t < 1000 + 2 * N) wr_rate((t - 1000) / N, (t - 1000) % N, $urandom % 4);
          if (t >= 1004 && t < 1004 + N * 256) wr_conn_rand((t - 1004) >> 8, (t - 1004) & 255);
        end
      end
    end
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule